// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Discriminator

This block decides when a frame transfer towards a panel with its own frame memory may begin. The panel reports its scan position on a tearing-effect pin. The block measures every active pulse on that pin in reference-clock ticks and compares the width with two programmed widths. A long pulse counts as a vertical sync and a shorter one as a horizontal sync. After each vertical sync the block counts horizontal syncs and emits a one-cycle start pulse when the programmed scan line is reached. A second wiring option carries vertical sync alone on the tearing-effect pin and horizontal sync on a separate pin. A third option ignores both pins and starts as soon as software requests it.

Software programs the mode, the two widths, the two polarities and the target line, then raises `go` for one cycle. In the immediate mode the start pulse follows at once. In either tearing-effect mode the block arms and fires once, at the first matching line after a vertical sync. Each pin passes through a synchronizer, so the pins may be fully asynchronous to `clk`.

Top module: `te_sync_discriminator`

## Requirements
- R1: After reset `trig` is low and the block is idle: it does not fire until `go` is seen.
- R2: With `trigMode` = 0, a `go` pulse while idle makes `trig` high for exactly the next cycle, whatever the pins do.
- R3: Mode encoding: `trigMode` 0 is immediate, 1 selects single-pin mode (both syncs on `teIn`), and both 2 and 3 select two-pin mode (vertical sync on `teIn`, horizontal sync on `hsIn`). In mode 0 no pin pulse has any effect.
- R4: A pulse width is the number of clock edges at which the synchronized pin sat at its active level. The active level of `teIn` is high when `vsPolHigh` = 1 and low when it is 0. `hsPolHigh` sets the active level of `hsIn` in the same way.
- R5: In single-pin mode a `teIn` pulse of width >= `vsWidth` is a vertical sync. A pulse of width >= `hsWidth` that is shorter than `vsWidth` is a horizontal sync. A shorter pulse is ignored.
- R6: In two-pin mode a `teIn` pulse of width >= `vsWidth` is a vertical sync, and shorter `teIn` pulses are ignored. An `hsIn` pulse of width >= `hsWidth` is a horizontal sync. When both end in the same cycle, the vertical sync wins and the horizontal one is dropped.
- R7: Once armed, horizontal syncs that come before the first vertical sync are not counted. Every vertical sync sets the line count back to zero. The block fires when the count of horizontal syncs since the last vertical sync equals `targetLine`. With `targetLine` = 0 it fires on the vertical sync itself.
- R8: `trig` is high from the third rising edge at which the pin is sampled at its inactive level after the pulse that fires it.
- R9: `trig` lasts one cycle, and each `go` produces at most one trigger. A `go` while armed is ignored, and after firing, further pulses do nothing until the next `go`.
- R10: `targetLine` is 11 bits wide, and the largest target, 2047, fires after exactly 2047 horizontal syncs.
- R11: The width measurement saturates at 2^CNT_BITS-1 (255 by default), so a pulse longer than that still reaches a `vsWidth` of 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; widths are counted in its ticks |
| rstN | input | 1 | Asynchronous reset, active low |
| teIn | input | 1 | Tearing-effect pin from the panel (asynchronous) |
| hsIn | input | 1 | Separate horizontal-sync pin, used in two-pin mode only |
| trigMode | input | 2 | 0 immediate, 1 single-pin, 2/3 two-pin |
| vsPolHigh | input | 1 | 1: `teIn` active high; 0: active low |
| hsPolHigh | input | 1 | 1: `hsIn` active high; 0: active low |
| hsWidth | input | 8 | Minimum horizontal-sync width in ticks |
| vsWidth | input | 8 | Minimum vertical-sync width in ticks |
| targetLine | input | 11 | Scan line at which to fire |
| go | input | 1 | One-cycle start request |
| trig | output | 1 | One-cycle transfer-start pulse |

## Verification
Three situations are hard to reach from the ports.
- Firing at the top line means driving 2047 horizontal pulses of minimum width after one vertical sync. The count is checked one line before and again at the last line.
- Width saturation needs a single pulse held for more than 255 ticks against a `vsWidth` of 255. If the width counter wrapped instead, the pulse would look like a horizontal sync.
- Both pins must end their pulses on the same clock. The bench forks two equal-width pulse drivers so the vertical-sync priority decides the line count.

A behavioural model, fed the same pin history, predicts `trig` on every clock.

// File: rtl/te_disc_pkg.sv
package te_disc_pkg;

  typedef enum logic [1:0] {
    MODE_IMM        = 2'd0,
    MODE_ONEPIN     = 2'd1,
    MODE_TWOPIN     = 2'd2,
    MODE_TWOPIN_ALT = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAITV = 2'd1,
    ST_COUNT = 2'd2
  } arm_state_e;

  // control -> datapath
  typedef struct packed {
    logic clrLine;
    logic incLine;
  } line_ctl_t;

  // datapath -> control
  typedef struct packed {
    logic vsEvt;
    logic hsEvt;
    logic hitNext;
    logic targetZero;
  } sync_evt_t;

endpackage

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_BITS    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pin,
  input  logic                polHigh,
  output logic                pulseEnd,
  output logic [CNT_BITS-1:0] width
);
  localparam logic [CNT_BITS-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_BITS-1:0]    runCnt;
  logic                   activeLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pin};
  end

  assign activeLvl = (syncQ[SYNC_STAGES-1] == polHigh);

  // run length of the active level, held at the maximum
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runCnt <= '0;
    else if (!activeLvl) runCnt <= '0;
    else if (runCnt != CNT_MAX) runCnt <= runCnt + 1'b1;
  end

  assign pulseEnd = !activeLvl && (runCnt != '0);
  assign width    = runCnt;

endmodule

// File: rtl/te_disc_datapath.sv
module te_disc_datapath
  import te_disc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_BITS    = 8,
  parameter int LINE_BITS   = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 teIn,
  input  logic                 hsIn,
  input  trig_mode_e           mode,
  input  logic                 vsPolHigh,
  input  logic                 hsPolHigh,
  input  logic [CNT_BITS-1:0]  hsWidth,
  input  logic [CNT_BITS-1:0]  vsWidth,
  input  logic [LINE_BITS-1:0] targetLine,
  input  line_ctl_t            ctl,
  output sync_evt_t            evt,
  output logic [LINE_BITS-1:0] lineCnt
);
  localparam int NUM_PINS = 2;  // index 0: teIn, index 1: hsIn

  logic [NUM_PINS-1:0] pins, pols, ends;
  logic [CNT_BITS-1:0] widths [NUM_PINS];
  logic teLong, teShort, hsPinHit;
  logic [LINE_BITS:0] nextLine;

  assign pins = {hsIn, teIn};
  assign pols = {hsPolHigh, vsPolHigh};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_meter
    te_pulse_meter #(.SYNC_STAGES(SYNC_STAGES), .CNT_BITS(CNT_BITS)) u_meter (
      .clk(clk), .rstN(rstN), .pin(pins[i]), .polHigh(pols[i]),
      .pulseEnd(ends[i]), .width(widths[i])
    );
  end

  assign teLong   = ends[0] && (widths[0] >= vsWidth);
  assign teShort  = ends[0] && !teLong && (widths[0] >= hsWidth);
  assign hsPinHit = ends[1] && (widths[1] >= hsWidth);

  always_comb begin
    evt.vsEvt = 1'b0;
    evt.hsEvt = 1'b0;
    unique case (mode)
      MODE_IMM:    ;
      MODE_ONEPIN: begin evt.vsEvt = teLong; evt.hsEvt = teShort; end
      default:     begin evt.vsEvt = teLong; evt.hsEvt = hsPinHit; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lineCnt <= '0;
    else if (ctl.clrLine) lineCnt <= '0;
    else if (ctl.incLine) lineCnt <= lineCnt + 1'b1;
  end

  assign nextLine       = {1'b0, lineCnt} + (LINE_BITS+1)'(1);
  assign evt.hitNext    = (nextLine == {1'b0, targetLine});
  assign evt.targetZero = (targetLine == '0);

endmodule

// File: rtl/te_disc_control.sv
module te_disc_control
  import te_disc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  trig_mode_e mode,
  input  logic       go,
  input  sync_evt_t  evt,
  output line_ctl_t  ctl,
  output arm_state_e armState,
  output logic       trig
);
  arm_state_e nextState;
  logic       trigNext;

  always_comb begin
    nextState = armState;
    ctl       = '0;
    trigNext  = 1'b0;
    unique case (armState)
      ST_IDLE: begin
        if (go) begin
          if (mode == MODE_IMM) trigNext  = 1'b1;
          else                  nextState = ST_WAITV;
        end
      end
      ST_WAITV, ST_COUNT: begin
        if (evt.vsEvt) begin
          ctl.clrLine = 1'b1;
          if (evt.targetZero) begin
            trigNext  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            nextState = ST_COUNT;
          end
        end else if (evt.hsEvt && armState == ST_COUNT) begin
          ctl.incLine = 1'b1;
          if (evt.hitNext) begin
            trigNext  = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armState <= ST_IDLE;
      trig     <= 1'b0;
    end else begin
      armState <= nextState;
      trig     <= trigNext;
    end
  end

endmodule

// File: rtl/te_sync_discriminator.sv
module te_sync_discriminator
  import te_disc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_BITS    = 8,
  parameter int LINE_BITS   = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 teIn,
  input  logic                 hsIn,
  input  logic [1:0]           trigMode,
  input  logic                 vsPolHigh,
  input  logic                 hsPolHigh,
  input  logic [CNT_BITS-1:0]  hsWidth,
  input  logic [CNT_BITS-1:0]  vsWidth,
  input  logic [LINE_BITS-1:0] targetLine,
  input  logic                 go,
  output logic                 trig
);
  trig_mode_e           mode;
  line_ctl_t            ctl;
  sync_evt_t            evt;
  arm_state_e           armState;
  logic [LINE_BITS-1:0] lineCnt;

  assign mode = trig_mode_e'(trigMode);

  te_disc_datapath #(.SYNC_STAGES(SYNC_STAGES), .CNT_BITS(CNT_BITS), .LINE_BITS(LINE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .teIn(teIn), .hsIn(hsIn), .mode(mode),
    .vsPolHigh(vsPolHigh), .hsPolHigh(hsPolHigh), .hsWidth(hsWidth), .vsWidth(vsWidth),
    .targetLine(targetLine), .ctl(ctl), .evt(evt), .lineCnt(lineCnt)
  );

  te_disc_control u_ctl (
    .clk(clk), .rstN(rstN), .mode(mode), .go(go), .evt(evt),
    .ctl(ctl), .armState(armState), .trig(trig)
  );

endmodule

// File: rtl/te_disc_checker.sv
module te_disc_checker
  import te_disc_pkg::*;
#(
  parameter int LINE_BITS = 11
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 go,
  input logic                 trig,
  input trig_mode_e           mode,
  input arm_state_e           armState,
  input logic                 vsEvt,
  input logic                 hsEvt,
  input logic [LINE_BITS-1:0] lineCnt,
  input logic [LINE_BITS-1:0] targetLine
);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> !trig);

  assert_immediate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armState == ST_IDLE && go && mode == MODE_IMM) |=> trig);

  assert_trig_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    trig |-> ($past(go && mode == MODE_IMM) || $past(vsEvt || hsEvt)));

  assert_line_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armState == ST_COUNT) |-> (lineCnt < targetLine));

  assert_prevsync_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armState == ST_WAITV && hsEvt && !vsEvt) |=> $stable(lineCnt));

  assert_vs_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armState == ST_COUNT && vsEvt && hsEvt && targetLine != '0) |=> (lineCnt == '0));

  assert_imm_no_events_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IMM) |-> (!vsEvt && !hsEvt));

endmodule

bind te_sync_discriminator te_disc_checker #(.LINE_BITS(LINE_BITS)) u_checker (
  .clk(clk), .rstN(rstN), .go(go), .trig(trig), .mode(mode), .armState(armState),
  .vsEvt(evt.vsEvt), .hsEvt(evt.hsEvt), .lineCnt(lineCnt), .targetLine(targetLine)
);

// File: tb/tb_te_sync_discriminator.sv
`timescale 1ns/1ps
module tb_te_sync_discriminator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        teIn = 1'b0, hsIn = 1'b0;
  logic [1:0]  trigMode = 2'd0;
  logic        vsPolHigh = 1'b1, hsPolHigh = 1'b1;
  logic [7:0]  hsWidth = 8'd3, vsWidth = 8'd8;
  logic [10:0] targetLine = 11'd0;
  logic        go = 1'b0;
  logic        trig;

  int checks = 0, errors = 0, trigCount = 0;
  bit done = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  te_sync_discriminator dut (
    .clk(clk), .rstN(rstN), .teIn(teIn), .hsIn(hsIn), .trigMode(trigMode),
    .vsPolHigh(vsPolHigh), .hsPolHigh(hsPolHigh), .hsWidth(hsWidth), .vsWidth(vsWidth),
    .targetLine(targetLine), .go(go), .trig(trig)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int teQ[$], hsQ[$];
  int teRun, hsRun, mState, mLine;
  bit mTrig;

  always @(posedge clk) begin
    if (!rstN) begin
      teQ = '{0, 0}; hsQ = '{0, 0};
      teRun = 0; hsRun = 0; mState = 0; mLine = 0; mTrig = 0;
    end else begin
      bit teAct, hsAct, teEnd, hsEnd, v, h, fire;
      int teW, hsW;
      teAct = (teQ[0] == int'(vsPolHigh));
      hsAct = (hsQ[0] == int'(hsPolHigh));
      teEnd = !teAct && teRun > 0;  teW = teRun;
      hsEnd = !hsAct && hsRun > 0;  hsW = hsRun;
      v = 0; h = 0; fire = 0;
      if (trigMode == 2'd1) begin
        v = teEnd && teW >= vsWidth;
        h = teEnd && !v && teW >= hsWidth;
      end else if (trigMode >= 2'd2) begin
        v = teEnd && teW >= vsWidth;
        h = hsEnd && hsW >= hsWidth;
      end
      case (mState)
        0: if (go) begin
             if (trigMode == 2'd0) fire = 1; else mState = 1;
           end
        default: begin
          if (v) begin
            mLine = 0;
            if (targetLine == 0) begin fire = 1; mState = 0; end
            else mState = 2;
          end else if (h && mState == 2) begin
            mLine++;
            if (mLine == targetLine) begin fire = 1; mState = 0; end
          end
        end
      endcase
      mTrig = fire;
      teRun = teAct ? ((teRun < 255) ? teRun + 1 : 255) : 0;
      hsRun = hsAct ? ((hsRun < 255) ? hsRun + 1 : 255) : 0;
      void'(teQ.pop_front()); teQ.push_back(int'(teIn));
      void'(hsQ.pop_front()); hsQ.push_back(int'(hsIn));
    end
  end

  always @(negedge clk) begin
    if (rstN) check(curReq, int'(trig), int'(mTrig), "trig vs model");
    if (trig) trigCount++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic tePulse(int w, int gap);
    @(negedge clk) teIn = vsPolHigh;
    repeat (w) @(negedge clk);
    teIn = ~vsPolHigh;
    repeat (gap) @(negedge clk);
  endtask

  task automatic hsPulse(int w, int gap);
    @(negedge clk) hsIn = hsPolHigh;
    repeat (w) @(negedge clk);
    hsIn = ~hsPolHigh;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pressGo();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
  endtask

  task automatic expectTrigs(string req, int base, int exp, string what);
    repeat (5) @(negedge clk);
    #1;
    check(req, trigCount - base, exp, what);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    #1;
    check("R1", int'(trig), 0, "trig during reset");
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check("R1", trigCount, 0, "no trigger after reset without go");

    // R2: immediate mode
    curReq = "R2"; base = trigCount;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    check("R2", int'(trig), 1, "trig in cycle after go");
    tePulse(12, 2);
    expectTrigs("R2", base, 1, "one trigger per immediate go");

    // R5 / R7: single-pin mode, active high
    curReq = "R5"; trigMode = 2'd1; hsWidth = 3; vsWidth = 8; targetLine = 3;
    repeat (3) @(negedge clk);
    base = trigCount;
    pressGo();
    tePulse(4, 3);                 // horizontal before vertical: ignored (R7)
    tePulse(10, 3);                // vertical
    tePulse(2, 3);                 // glitch below hsWidth: ignored (R5)
    tePulse(3, 3);                 // line 1
    tePulse(7, 3);                 // line 2 (just below vsWidth)
    expectTrigs("R7", base, 0, "no trigger before target line");
    tePulse(5, 3);                 // line 3
    expectTrigs("R5", base, 1, "trigger at third classified line");

    // R4: active-low tearing-effect pin
    curReq = "R4";
    @(negedge clk) begin teIn = 1'b1; vsPolHigh = 1'b0; targetLine = 1; end
    repeat (6) @(negedge clk);
    base = trigCount;
    pressGo();
    tePulse(9, 3);
    tePulse(3, 3);
    expectTrigs("R4", base, 1, "active-low pulses classified");

    // R6: two-pin mode (value 2), active-low horizontal pin
    curReq = "R6";
    @(negedge clk) begin
      teIn = 1'b0; vsPolHigh = 1'b1; hsIn = 1'b1; hsPolHigh = 1'b0;
      trigMode = 2'd2; vsWidth = 4; hsWidth = 3; targetLine = 2;
    end
    repeat (6) @(negedge clk);
    base = trigCount;
    pressGo();
    hsPulse(3, 3);                 // before vertical: ignored
    tePulse(4, 3);                 // vertical
    tePulse(2, 3);                 // short pulse on teIn: ignored in two-pin mode
    hsPulse(2, 3);                 // below hsWidth: ignored
    hsPulse(3, 3);                 // line 1
    expectTrigs("R6", base, 0, "only one valid line so far");
    hsPulse(3, 3);                 // line 2
    expectTrigs("R6", base, 1, "trigger from horizontal pin");

    // R3 / R6: value 3 behaves as two-pin; simultaneous ends -> vertical wins
    curReq = "R3";
    @(negedge clk) begin trigMode = 2'd3; vsWidth = 2; end
    repeat (3) @(negedge clk);
    base = trigCount;
    pressGo();
    tePulse(3, 3);
    hsPulse(3, 3);                 // line 1
    fork
      tePulse(4, 3);
      hsPulse(4, 3);
    join                           // restart: count back to 0
    hsPulse(3, 3);                 // line 1 again
    expectTrigs("R6", base, 0, "simultaneous end gives vertical priority");
    hsPulse(3, 3);
    expectTrigs("R3", base, 1, "mode value 3 is two-pin mode");

    // R3: pins have no effect in immediate mode
    @(negedge clk) trigMode = 2'd0;
    base = trigCount;
    tePulse(10, 2); hsPulse(4, 2); tePulse(3, 2);
    expectTrigs("R3", base, 0, "pins ignored in immediate mode");

    // R7 / R8: target 0 fires on vertical sync, timing of the pulse
    curReq = "R8";
    @(negedge clk) begin trigMode = 2'd1; vsWidth = 8; hsWidth = 3; targetLine = 0; end
    repeat (3) @(negedge clk);
    base = trigCount;
    pressGo();
    tePulse(4, 3);                 // horizontal: does not fire
    tePulse(9, 0);                 // vertical, inactive driven now
    @(negedge clk) check("R8", int'(trig), 0, "trig low 1 cycle after end");
    @(negedge clk) check("R8", int'(trig), 0, "trig low 2 cycles after end");
    @(negedge clk) check("R8", int'(trig), 1, "trig high 3 cycles after end");
    expectTrigs("R7", base, 1, "target 0 fires on vertical sync");

    // R9: go while armed ignored, single trigger per go
    curReq = "R9"; targetLine = 2;
    base = trigCount;
    pressGo();
    tePulse(9, 3);
    pressGo();                     // while armed: ignored
    tePulse(3, 3);
    tePulse(3, 3);                 // fires
    tePulse(3, 3);
    tePulse(9, 3);
    tePulse(3, 3);
    tePulse(3, 3);
    expectTrigs("R9", base, 1, "one trigger per go");

    // R10: top target line 2047 in two-pin mode
    curReq = "R10";
    @(negedge clk) begin trigMode = 2'd2; hsPolHigh = 1'b1; hsIn = 1'b0;
                         hsWidth = 2; vsWidth = 4; targetLine = 11'd2047; end
    repeat (4) @(negedge clk);
    base = trigCount;
    pressGo();
    tePulse(4, 3);
    for (int i = 0; i < 2046; i++) hsPulse(2, 2);
    expectTrigs("R10", base, 0, "no trigger at line 2046");
    hsPulse(2, 3);
    expectTrigs("R10", base, 1, "trigger at line 2047");

    // R11: saturating width reaches vsWidth 255
    curReq = "R11";
    @(negedge clk) begin trigMode = 2'd1; vsWidth = 8'd255; hsWidth = 4; targetLine = 0; end
    repeat (3) @(negedge clk);
    base = trigCount;
    pressGo();
    tePulse(300, 3);
    expectTrigs("R11", base, 1, "long pulse saturates and is vertical sync");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule